// File: doc/BRIEF.md
# Looped Dwell Sequencer

The block is a small control engine that steps between two working phases, called A and B, after a start strobe. Each phase is held for a run-time number of clock cycles. The A-then-B pass repeats a run-time number of times, and then the machine falls back to idle. The engine is meant to pace serial framing logic, such as a bit-cell timer with a setup part and a hold part repeated for every bit. The serial data path itself is not part of this block.

Three registered counters replace a long chain of unrolled states. A phase-A dwell counter advances in A and is zero elsewhere. A phase-B dwell counter advances in B and is zero elsewhere. A pass counter advances only when B hands back to A. The three lengths are captured when the start strobe is accepted, so the caller may change the length inputs while the machine runs.

Top module: `lfsm_looped_timer`

## Requirements
- R1: While the synchronous reset is high, and in the first cycle after it is released, `state_o` is 0 (idle), `busy_o` is 0 and `done_o` is 0.
- R2: A start strobe sampled while idle moves `state_o` to 1 (phase A) in the next cycle.
- R3: On every pass the machine holds phase A (`state_o` = 1) for exactly `len_a_i` consecutive cycles, then enters phase B (`state_o` = 2).
- R4: On every pass the machine holds phase B for exactly `len_b_i` consecutive cycles.
- R5: The machine performs exactly `loops_i` A-to-B transitions. After the last B cycle of the final pass it returns to idle, so a run is busy for `loops_i*(len_a_i+len_b_i)` cycles.
- R6: `done_o` is high for exactly one cycle: the first idle cycle after a completed run. It stays low at all other times.
- R7: A start strobe that arrives while the machine is busy is ignored. The running sequence continues unchanged.
- R8: The lengths are sampled only when a start is accepted. Changes to the length inputs during a run have no effect on that run.
- R9: With both dwell lengths equal to 1, the state alternates A, B, A, B, ... on every cycle for `2*loops_i` cycles.
- R10: A length input of 0 is treated as 1.
- R11: The pass counter holds its value while the machine stays in phase A and is zero while idle.
- R12: `busy_o` is high exactly when `state_o` is 1 or 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start strobe, accepted only while idle |
| len_a_i | input | AW (8) | Phase-A dwell in cycles (0 treated as 1) |
| len_b_i | input | BW (8) | Phase-B dwell in cycles (0 treated as 1) |
| loops_i | input | KW (8) | Number of A-to-B passes (0 treated as 1) |
| state_o | output | 2 | 0 idle, 1 phase A, 2 phase B |
| busy_o | output | 1 | High while in phase A or B |
| done_o | output | 1 | One-cycle pulse after the last B cycle |

## Verification
The assertions compare the counters against the captured lengths, not against the raw inputs. They therefore assume the captured values are never zero. The normalisation on capture provides that, and the bench still drives zero-valued lengths to exercise it. The properties also assume the reset is held for at least one edge before a run. The stimulus changes the start strobe and the lengths only on falling edges, and it also drives starts and length changes in the middle of a run, which the checker must show are harmless.

// File: rtl/lfsm_pkg.sv
package lfsm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_A    = 2'b01,
    ST_B    = 2'b10
  } lfsm_state_e;

  // A dwell or pass counter has reached its final value for a length len (len >= 1).
  function automatic logic at_last(input int unsigned cnt, input int unsigned len);
    return (cnt + 1) >= len;
  endfunction

  // Number of busy cycles for one complete run, with lengths already normalised.
  function automatic int unsigned run_cycles(input int unsigned na, input int unsigned nb,
                                             input int unsigned nk);
    return nk * (na + nb);
  endfunction

endpackage

// File: rtl/lfsm_counter.sv
module lfsm_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst || clr) q <= '0;
    else if (inc)   q <= q + 1'b1;
  end
endmodule

// File: rtl/lfsm_len_bank.sv
module lfsm_len_bank #(
  parameter int AW = 8,
  parameter int BW = 8,
  parameter int KW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] a_raw,
  input  logic [BW-1:0] b_raw,
  input  logic [KW-1:0] k_raw,
  output logic [AW-1:0] a_q,
  output logic [BW-1:0] b_q,
  output logic [KW-1:0] k_q
);
  function automatic logic [AW-1:0] norm_a(input logic [AW-1:0] v);
    return (v == '0) ? AW'(1) : v;
  endfunction
  function automatic logic [BW-1:0] norm_b(input logic [BW-1:0] v);
    return (v == '0) ? BW'(1) : v;
  endfunction
  function automatic logic [KW-1:0] norm_k(input logic [KW-1:0] v);
    return (v == '0) ? KW'(1) : v;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= AW'(1);
      b_q <= BW'(1);
      k_q <= KW'(1);
    end else if (load) begin
      a_q <= norm_a(a_raw);
      b_q <= norm_b(b_raw);
      k_q <= norm_k(k_raw);
    end
  end
endmodule

// File: rtl/lfsm_ctrl.sv
module lfsm_ctrl
  import lfsm_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        a_last,
  input  logic        b_last,
  input  logic        k_last,
  output lfsm_state_e st,
  output logic        accept,
  output logic        a_exit,
  output logic        b_exit,
  output logic        loop_back,
  output logic        run_end,
  output logic        done
);
  lfsm_state_e st_nx;

  always_comb begin
    accept    = (st == ST_IDLE) && start;
    a_exit    = (st == ST_A) && a_last;
    b_exit    = (st == ST_B) && b_last;
    run_end   = b_exit && k_last;
    loop_back = b_exit && !k_last;
    st_nx     = st;
    unique case (st)
      ST_IDLE: if (accept)    st_nx = ST_A;
      ST_A:    if (a_exit)    st_nx = ST_B;
      ST_B:    if (run_end)   st_nx = ST_IDLE;
               else if (b_exit) st_nx = ST_A;
      default:                st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= ST_IDLE;
      done <= 1'b0;
    end else begin
      st   <= st_nx;
      done <= run_end;
    end
  end
endmodule

// File: rtl/lfsm_looped_timer.sv
module lfsm_looped_timer
  import lfsm_pkg::*;
#(
  parameter int AW = 8,
  parameter int BW = 8,
  parameter int KW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [AW-1:0] len_a_i,
  input  logic [BW-1:0] len_b_i,
  input  logic [KW-1:0] loops_i,
  output logic [1:0]    state_o,
  output logic          busy_o,
  output logic          done_o
);
  lfsm_state_e   st;
  logic          accept, a_exit, b_exit, loop_back, run_end, done;
  logic          a_last, b_last, k_last;
  logic [AW-1:0] len_a_q, cnt_i;
  logic [BW-1:0] len_b_q, cnt_j;
  logic [KW-1:0] len_n_q, cnt_k;

  lfsm_len_bank #(.AW(AW), .BW(BW), .KW(KW)) u_len (
    .clk(clk), .rst(rst), .load(accept),
    .a_raw(len_a_i), .b_raw(len_b_i), .k_raw(loops_i),
    .a_q(len_a_q), .b_q(len_b_q), .k_q(len_n_q)
  );

  assign a_last = at_last(32'(cnt_i), 32'(len_a_q));
  assign b_last = at_last(32'(cnt_j), 32'(len_b_q));
  assign k_last = at_last(32'(cnt_k), 32'(len_n_q));

  // Phase-A dwell: counts in A, zero elsewhere.
  lfsm_counter #(.W(AW)) u_cnt_i (
    .clk(clk), .rst(rst), .clr((st != ST_A) || a_exit), .inc(st == ST_A), .q(cnt_i)
  );
  // Phase-B dwell: counts in B, zero elsewhere.
  lfsm_counter #(.W(BW)) u_cnt_j (
    .clk(clk), .rst(rst), .clr((st != ST_B) || b_exit), .inc(st == ST_B), .q(cnt_j)
  );
  // Pass counter: advances only on the B-to-A hand-back.
  lfsm_counter #(.W(KW)) u_cnt_k (
    .clk(clk), .rst(rst), .clr((st == ST_IDLE) || run_end), .inc(loop_back), .q(cnt_k)
  );

  lfsm_ctrl u_ctrl (
    .clk(clk), .rst(rst), .start(start_i),
    .a_last(a_last), .b_last(b_last), .k_last(k_last),
    .st(st), .accept(accept), .a_exit(a_exit), .b_exit(b_exit),
    .loop_back(loop_back), .run_end(run_end), .done(done)
  );

  assign state_o = st;
  assign busy_o  = (st != ST_IDLE);
  assign done_o  = done;
endmodule

// File: rtl/lfsm_looped_timer_chk.sv
module lfsm_looped_timer_chk
  import lfsm_pkg::*;
#(
  parameter int AW = 8,
  parameter int BW = 8,
  parameter int KW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          start_i,
  input logic [1:0]    state_o,
  input logic          done_o,
  input logic [AW-1:0] cnt_i,
  input logic [BW-1:0] cnt_j,
  input logic [KW-1:0] cnt_k,
  input logic [AW-1:0] len_a_q,
  input logic [BW-1:0] len_b_q,
  input logic [KW-1:0] len_n_q
);
  assert_enter_a_R2: assert property (@(posedge clk) disable iff (rst)
    (state_o == ST_IDLE && start_i) |=> state_o == ST_A);

  assert_hold_a_R3: assert property (@(posedge clk) disable iff (rst)
    (state_o == ST_A && cnt_i != len_a_q - 1'b1) |=> state_o == ST_A);

  assert_leave_a_R3: assert property (@(posedge clk) disable iff (rst)
    (state_o == ST_A && cnt_i == len_a_q - 1'b1) |=> state_o == ST_B);

  assert_hold_b_R4: assert property (@(posedge clk) disable iff (rst)
    (state_o == ST_B && cnt_j != len_b_q - 1'b1) |=> state_o == ST_B);

  assert_finish_R5: assert property (@(posedge clk) disable iff (rst)
    (state_o == ST_B && cnt_j == len_b_q - 1'b1 && cnt_k == len_n_q - 1'b1)
      |=> (state_o == ST_IDLE && done_o));

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  assert_ignore_busy_start_R7: assert property (@(posedge clk) disable iff (rst)
    (state_o != ST_IDLE) |=> ($stable(len_a_q) && $stable(len_b_q) && $stable(len_n_q)));

  assert_k_hold_in_a_R11: assert property (@(posedge clk) disable iff (rst)
    (state_o == ST_A) |=> (state_o != ST_A || $stable(cnt_k)));

  assert_k_idle_zero_R11: assert property (@(posedge clk) disable iff (rst)
    (state_o == ST_IDLE) |-> cnt_k == '0);

  assert_k_bound_R5: assert property (@(posedge clk) disable iff (rst)
    cnt_k < len_n_q);
endmodule

bind lfsm_looped_timer lfsm_looped_timer_chk #(.AW(AW), .BW(BW), .KW(KW)) u_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .state_o(state_o), .done_o(done_o),
  .cnt_i(cnt_i), .cnt_j(cnt_j), .cnt_k(cnt_k),
  .len_a_q(len_a_q), .len_b_q(len_b_q), .len_n_q(len_n_q)
);

// File: tb/lfsm_looped_timer_tb.sv
`timescale 1ns/1ps
module lfsm_looped_timer_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic [7:0] len_a_i = '0, len_b_i = '0, loops_i = '0;
  logic [1:0] state_o;
  logic       busy_o, done_o;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  lfsm_looped_timer u_dut (
    .clk(clk), .rst(rst), .start_i(start_i),
    .len_a_i(len_a_i), .len_b_i(len_b_i), .loops_i(loops_i),
    .state_o(state_o), .busy_o(busy_o), .done_o(done_o)
  );

  // {len_a, len_b, loops, expected busy cycles}
  localparam logic [39:0] VEC [8] = '{
    {8'd1, 8'd1, 8'd1, 16'd2},
    {8'd1, 8'd1, 8'd4, 16'd8},
    {8'd3, 8'd2, 8'd2, 16'd10},
    {8'd2, 8'd5, 8'd3, 16'd21},
    {8'd4, 8'd1, 8'd1, 16'd5},
    {8'd1, 8'd3, 8'd2, 16'd8},
    {8'd0, 8'd0, 8'd3, 16'd6},
    {8'd5, 8'd5, 8'd5, 16'd50}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int expect_state(input int c, input int ea, input int eb);
    int pos = c % (ea + eb);
    return (pos < ea) ? 1 : 2;
  endfunction

  // Drives start on a falling edge and follows the run cycle by cycle.
  // Optionally injects a busy start with new lengths at cycle inj_at (R7, R8).
  task automatic run_vec(input int na, input int nb, input int nk, input int expc,
                         input int inj_at);
    int ea = (na == 0) ? 1 : na;
    int eb = (nb == 0) ? 1 : nb;
    int ek = (nk == 0) ? 1 : nk;
    chk("R5 table cycles", expc, ek * (ea + eb));
    start_i = 1'b1; len_a_i = 8'(na); len_b_i = 8'(nb); loops_i = 8'(nk);
    @(negedge clk);
    start_i = 1'b0;
    chk("R2 enter A", int'(state_o), 1);
    for (int c = 0; c < expc; c++) begin
      chk("R3/R4/R9/R10 phase", int'(state_o), expect_state(c, ea, eb));
      chk("R12 busy", int'(busy_o), 1);
      chk("R6 no early done", int'(done_o), 0);
      if (c == inj_at) begin
        start_i = 1'b1; len_a_i = 8'd1; len_b_i = 8'd1; loops_i = 8'd1;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
    end
    start_i = 1'b0;
    chk("R5 idle after run", int'(state_o), 0);
    chk("R12 busy low", int'(busy_o), 0);
    chk("R6 done pulse", int'(done_o), 1);
    @(negedge clk);
    chk("R6 done one cycle", int'(done_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset state", int'(state_o), 0);
    chk("R1 reset busy", int'(busy_o), 0);
    chk("R1 reset done", int'(done_o), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 state after release", int'(state_o), 0);
    chk("R1 done after release", int'(done_o), 0);

    foreach (VEC[v]) begin
      run_vec(int'(VEC[v][39:32]), int'(VEC[v][31:24]), int'(VEC[v][23:16]),
              int'(VEC[v][15:0]), -1);
      @(negedge clk);
    end

    // R7, R8: busy start with new lengths is ignored; run keeps 2/2/2 shape.
    run_vec(2, 2, 2, 8, 3);
    // R8: lengths change during a run with no strobe.
    start_i = 1'b1; len_a_i = 8'd2; len_b_i = 8'd1; loops_i = 8'd2;
    @(negedge clk);
    start_i = 1'b0; len_a_i = 8'd7; len_b_i = 8'd7; loops_i = 8'd7;
    for (int c = 0; c < 6; c++) begin
      chk("R8 captured lengths", int'(state_o), expect_state(c, 2, 1));
      @(negedge clk);
    end
    chk("R8 run length kept", int'(state_o), 0);
    chk("R8 done", int'(done_o), 1);

    // Idle with no start: no done, stays idle (R6).
    repeat (4) begin
      @(negedge clk);
      chk("R6 idle no done", int'(done_o), 0);
      chk("R1 idle holds", int'(state_o), 0);
    end

    // Reset mid-run (R1).
    start_i = 1'b1; len_a_i = 8'd3; len_b_i = 8'd3; loops_i = 8'd3;
    @(negedge clk);
    start_i = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 reset mid-run state", int'(state_o), 0);
    chk("R1 reset mid-run busy", int'(busy_o), 0);
    chk("R1 reset mid-run done", int'(done_o), 0);
    @(negedge clk);
    run_vec(1, 1, 3, 6, -1);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got 0 expected 1 (run completion)");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule